// File: doc/BRIEF.md
# Two-Road Intersection Light Sequencer

This block drives the lamps of a crossing where two roads, A and B, take turns. Each road has a presence sensor that reads 1 while vehicles are waiting or passing. A two-bit phase register steps through four phases: A go, A caution, B go, B caution. A go phase lasts as long as its own road's sensor stays high. Each caution phase lasts exactly one clock.

The lamp outputs are decoded from the phase register alone, so they never respond to the sensors in the same cycle. The next phase is formed by fixed two-level equations on the phase bits and the two sensors. Each road's lamp is driven with a two-bit code: 00 for go (green), 01 for caution (yellow) and 10 for stop (red).

Top module: `xroad_lights`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `light_a` is 00 and `light_b` is 10 (A go).
- R2: In A go with `sense_a` = 1, the block stays in A go at the next clock edge.
- R3: In A go with `sense_a` = 0, the next clock edge moves it to A caution (`light_a` 01, `light_b` 10).
- R4: A caution lasts one cycle and is followed by B go (`light_a` 10, `light_b` 00), whatever the sensors read.
- R5: In B go with `sense_b` = 1, the block stays in B go at the next clock edge.
- R6: In B go with `sense_b` = 0, the next clock edge moves it to B caution (`light_a` 10, `light_b` 01).
- R7: B caution lasts one cycle and is followed by A go, whatever the sensors read.
- R8: The code 11 never appears on `light_a` or `light_b`.
- R9: In every cycle, at least one of the two roads shows stop (10).
- R10: The sensor of the road that is currently stopped has no effect on the next phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high, forces A go |
| sense_a | input | 1 | Road A presence sensor, 1 = traffic |
| sense_b | input | 1 | Road B presence sensor, 1 = traffic |
| light_a | output | 2 | Road A lamp code: 00 go, 01 caution, 10 stop |
| light_b | output | 2 | Road B lamp code: 00 go, 01 caution, 10 stop |

## Verification
The sensors are sampled at a rising edge, and the lamps show the resulting phase right after that same edge. The latency from a sensor change to the lamps is therefore one edge, and reset acts at once. The bench drives the sensors 1 ns after each falling edge. Its behavioural model advances at each rising edge, and both lamp outputs are compared with the model at every falling edge, so a result is never sampled at the edge that produces it. A mid-run reset and long stretches of held sensors cover the hold and caution timing.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    localparam int PHASE_W = 2;
    localparam int LAMP_W  = 2;
    localparam int ROADS   = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_A_GO   = 2'b00,
        PH_A_WARN = 2'b01,
        PH_B_GO   = 2'b10,
        PH_B_WARN = 2'b11
    } phase_t;

    localparam logic [LAMP_W-1:0] LAMP_GO   = 2'b00;
    localparam logic [LAMP_W-1:0] LAMP_WARN = 2'b01;
    localparam logic [LAMP_W-1:0] LAMP_STOP = 2'b10;

    typedef struct packed {
        phase_t phase;
    } ctl_t;

    localparam ctl_t CTL_RST = '{phase: PH_A_GO};

    function automatic phase_t go_of(input int road);
        return (road == 0) ? PH_A_GO : PH_B_GO;
    endfunction

    function automatic phase_t warn_of(input int road);
        return (road == 0) ? PH_A_WARN : PH_B_WARN;
    endfunction

endpackage

// File: rtl/tlc_next.sv
module tlc_next
    import tlc_pkg::*;
(
    input  phase_t cur_i,
    input  logic   sense_a_i,
    input  logic   sense_b_i,
    output phase_t nxt_o
);
    logic hi_q, lo_q;
    logic hi_d, lo_d;

    always_comb begin
        hi_q = cur_i[1];
        lo_q = cur_i[0];
        // upper bit: toggles whenever the lower bit is set
        hi_d = hi_q ^ lo_q;
        // lower bit: leave a go phase only when its own road is empty
        lo_d = (~hi_q & ~lo_q & ~sense_a_i) | (hi_q & ~lo_q & ~sense_b_i);
        nxt_o = phase_t'({hi_d, lo_d});
    end
endmodule

// File: rtl/tlc_lamp.sv
module tlc_lamp
    import tlc_pkg::*;
#(
    parameter phase_t GO_PH   = PH_A_GO,
    parameter phase_t WARN_PH = PH_A_WARN
) (
    input  phase_t            phase_i,
    output logic [LAMP_W-1:0] lamp_o
);
    always_comb begin
        if (phase_i == GO_PH)
            lamp_o = LAMP_GO;
        else if (phase_i == WARN_PH)
            lamp_o = LAMP_WARN;
        else
            lamp_o = LAMP_STOP;
    end
endmodule

// File: rtl/xroad_lights.sv
module xroad_lights
    import tlc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sense_a,
    input  logic        sense_b,
    output logic [1:0]  light_a,
    output logic [1:0]  light_b
);
    ctl_t   ctl_d, ctl_q;
    phase_t nxt_phase;
    logic [LAMP_W-1:0] lamp_w [ROADS];

    tlc_next u_next (
        .cur_i     (ctl_q.phase),
        .sense_a_i (sense_a),
        .sense_b_i (sense_b),
        .nxt_o     (nxt_phase)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.phase = nxt_phase;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            ctl_q <= CTL_RST;
        else
            ctl_q <= ctl_d;
    end

    for (genvar r = 0; r < ROADS; r++) begin : g_road
        tlc_lamp #(
            .GO_PH   (go_of(r)),
            .WARN_PH (warn_of(r))
        ) u_lamp (
            .phase_i (ctl_q.phase),
            .lamp_o  (lamp_w[r])
        );
    end

    assign light_a = lamp_w[0];
    assign light_b = lamp_w[1];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $fell(rst) |-> (light_a == LAMP_GO && light_b == LAMP_STOP));

    // R2
    hold_a_chk: assert property (@(posedge clk) disable iff (rst)
        (light_a == LAMP_GO && sense_a) |=> light_a == LAMP_GO);

    // R3
    a_to_warn_chk: assert property (@(posedge clk) disable iff (rst)
        (light_a == LAMP_GO && !sense_a) |=> (light_a == LAMP_WARN && light_b == LAMP_STOP));

    // R4
    a_warn_short_chk: assert property (@(posedge clk) disable iff (rst)
        (light_a == LAMP_WARN) |=> (light_a == LAMP_STOP && light_b == LAMP_GO));

    // R5
    hold_b_chk: assert property (@(posedge clk) disable iff (rst)
        (light_b == LAMP_GO && sense_b) |=> light_b == LAMP_GO);

    // R6
    b_to_warn_chk: assert property (@(posedge clk) disable iff (rst)
        (light_b == LAMP_GO && !sense_b) |=> (light_b == LAMP_WARN && light_a == LAMP_STOP));

    // R7
    b_warn_short_chk: assert property (@(posedge clk) disable iff (rst)
        (light_b == LAMP_WARN) |=> (light_a == LAMP_GO && light_b == LAMP_STOP));

    // R8
    no_code11_chk: assert property (@(posedge clk) disable iff (rst)
        (light_a != 2'b11 && light_b != 2'b11));

    // R9
    one_road_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (light_a == LAMP_STOP || light_b == LAMP_STOP));

endmodule

// File: tb/test_xroad_lights.sv
`timescale 1ns/1ps
module test_xroad_lights;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sense_a = 1'b0;
    logic       sense_b = 1'b0;
    logic [1:0] light_a, light_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int cycles = 0;

    int    ref_ph = 0;      // 0 A go, 1 A caution, 2 B go, 3 B caution
    string ref_tag = "R1";
    logic [31:0] lfsr = 32'hACE1_2025;

    xroad_lights i_xroad_lights (
        .clk     (clk),
        .rst     (rst),
        .sense_a (sense_a),
        .sense_b (sense_b),
        .light_a (light_a),
        .light_b (light_b)
    );

    always #2.5 clk = ~clk;

    // behavioural reference, advances on every rising edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            ref_ph  = 0;
            ref_tag = "R1";
        end else begin
            case (ref_ph)
                0: if (sense_a) begin ref_tag = "R2,R10"; end
                   else begin ref_ph = 1; ref_tag = "R3"; end
                1: begin ref_ph = 2; ref_tag = "R4"; end
                2: if (sense_b) begin ref_tag = "R5,R10"; end
                   else begin ref_ph = 3; ref_tag = "R6"; end
                default: begin ref_ph = 0; ref_tag = "R7"; end
            endcase
        end
    end

    function automatic logic [1:0] exp_a(input int ph);
        case (ph)
            0: return 2'b00;
            1: return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [1:0] exp_b(input int ph);
        case (ph)
            2: return 2'b00;
            3: return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (light_a !== exp_a(ref_ph) || light_b !== exp_b(ref_ph)) begin
                n_bad++;
                $display("FAIL %s: lights a=%b b=%b expected a=%b b=%b",
                         ref_tag, light_a, light_b, exp_a(ref_ph), exp_b(ref_ph));
            end
            n_cmp++;
            if (light_a === 2'b11 || light_b === 2'b11) begin
                n_bad++;
                $display("FAIL R8: lights a=%b b=%b expected no 11", light_a, light_b);
            end
            n_cmp++;
            if (light_a !== 2'b10 && light_b !== 2'b10) begin
                n_bad++;
                $display("FAIL R9: lights a=%b b=%b expected one road at 10", light_a, light_b);
            end
        end
    end

    task automatic step(input logic a, input logic b);
        @(negedge clk);
        #1;
        sense_a = a;
        sense_b = b;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) step(1'b1, 1'b1);          // R1: reset holds A go
        @(negedge clk); #1; rst = 1'b0;
        for (int i = 0; i < 6; i++) step(1'b1, i[0]); // R2, R10: A holds, B sensor toggles
        step(1'b0, 1'b1);                      // R3 then R4
        for (int i = 0; i < 6; i++) step(i[0], 1'b1); // R5, R10
        step(1'b0, 1'b0);                      // R6 then R7
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0); // idle cycling
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1); // both busy
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[3] | lfsr[7], lfsr[5] & ~lfsr[9] | lfsr[11]);
            if (i == 1500) begin
                @(negedge clk); #1; rst = 1'b1;   // R1 mid-run
                step(1'b0, 1'b0);
                @(negedge clk); #1; rst = 1'b0;
            end
        end
        step(1'b0, 1'b0);
        finish_run();
    end

    initial begin
        wait (cycles > 50000);
        n_bad++;
        $display("FAIL watchdog: cycles=%0d expected fewer than 50000", cycles);
        finish_run();
    end

endmodule